// File: doc/BRIEF.md
# Channel command word chain interpreter

This block runs a channel program for a single subchannel. Given a start address, it fetches 64-bit command words from memory one at a time over a request/grant port. It checks each word and carries out the housekeeping commands itself: no-operation, transfer-in-channel jump, basic sense and sense-ID. Any other command goes to an attached device over a request/acknowledge port. The block follows command chaining and jumps until the program ends, then reports exactly one final outcome to the subchannel controller.

A word is laid out most significant byte first: command code in bits 63:56, flags in 55:48, byte count in 47:32 and data address in 31:0. Flag bits: data chain 0x80, command chain 0x40, suppress length 0x20, suspend 0x02. Commands: no-op 0x03, basic sense 0x04, sense-ID 0xE4, jump 0x08. The natural size of basic sense is `SENSE_BYTES` (default 32) and that of sense-ID is `SID_BYTES` (default 8). The only data the block moves itself is the leading sense byte, which it reports on `byte0_o` together with a residual count.

The outcome codes are: 0 success, 1 unit check, 2 data check, 3 program check, 4 busy, 5 suspended. Device responses are: 0 accepted, 1 unsupported, 2 busy, 3 fault. The final `pc_o` holds the address of the word that ended the program. When the end came at a fetch, it holds the address that could not be fetched.

Top module: `ccw_chain_engine`

## Requirements
- R1: A fetch from program address 0, or a word whose command low nibble is 0, ends the program with outcome 3 (program check).
- R2: A jump (low nibble 8) ends with outcome 3 in any of these cases: its high nibble is non-zero, it directly follows another jump, or it has command chain (0x40) or data chain (0x80) set. Otherwise the next fetch is taken from its data address.
- R3: A word whose suspend flag (0x02) is set ends with outcome 5 and is not executed. It leaves the stored sense byte untouched and reports no alert and deferred code 0.
- R4: Length is checked unless suppress length (0x20) is set and data chain (0x80) is clear. A checked basic sense or sense-ID whose count differs from its natural size ends with outcome 3.
- R5: After a successful non-jump word, command chain (0x40) set moves the program address forward by 8 and fetches again. When it is clear, the program ends with outcome 0, `alert_o` low and `dcc_o` 0.
- R6: Sense-ID moves min(count, `SID_BYTES`) bytes and reports count minus that as the residual. Its leading byte is 0xFF when at least 4 bytes move, otherwise 0x00.
- R7: Basic sense reports the stored leading sense byte and the residual count minus min(count, `SENSE_BYTES`). It then zeroes the stored sense.
- R8: These conditions end with outcome 2 (data check): a device fault response, or a fetch that completes with a memory fault. An unsupported device response ends with outcome 1 (unit check) and sets the stored leading sense byte to 0x80. An accepted device response counts as a successful word.
- R9: A busy device response ends with outcome 4, `dcc_o` = 1 and `alert_o` high.
- R10: A program that has fetched `MAX_STEPS` (default 256) words ends with outcome 3 instead of fetching another one.
- R11: During and after reset, with no start, `done_o`, `mem_req_o` and `dev_req_o` are low.
- R12: Each run raises `done_o` for exactly one cycle, and memory and device requests are never raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a program; taken only when idle |
| start_addr_i | input | 32 | Address of the first word |
| mem_req_o | output | 1 | Word fetch request |
| mem_addr_o | output | 32 | Fetch address (current program address) |
| mem_gnt_i | input | 1 | Fetch grant; data and fault valid with it |
| mem_fault_i | input | 1 | Fetch access fault |
| mem_rdata_i | input | 64 | Fetched word |
| dev_req_o | output | 1 | Device command request, held until acknowledge |
| dev_cmd_o | output | 8 | Command code to the device |
| dev_flags_o | output | 8 | Flags to the device |
| dev_count_o | output | 16 | Byte count to the device |
| dev_addr_o | output | 32 | Data address to the device |
| dev_ack_i | input | 1 | Device acknowledge |
| dev_resp_i | input | 2 | Device response code |
| done_o | output | 1 | One-cycle end-of-program pulse |
| outcome_o | output | 3 | Final outcome code |
| dcc_o | output | 2 | Deferred condition code |
| alert_o | output | 1 | Alert status |
| residual_o | output | 16 | Residual count of the last executed word |
| byte0_o | output | 8 | Leading sense byte of the last executed word |
| pc_o | output | 32 | Program address at the end |

## Verification
A wrong program address or a stale jump history shows up at the ports one fetch later: either a fetch goes to an unexpected address, or a legal jump is reported as a program check. A corrupted sense byte stays hidden until the next basic sense, which can be several programs later. For that reason the vector order deliberately carries the 0x80 sense byte from an unsupported command, across a suspended program, into two consecutive basic-sense reads. Step-count errors need a long looping program and become visible only as the number of fetches granted before the final program check.

// File: rtl/ccw_pkg.sv
package ccw_pkg;

  localparam logic [7:0] OP_NOOP   = 8'h03;
  localparam logic [7:0] OP_BSENSE = 8'h04;
  localparam logic [7:0] OP_SID    = 8'hE4;
  localparam logic [7:0] OP_JUMP   = 8'h08;

  localparam int FL_DC   = 7;
  localparam int FL_CC   = 6;
  localparam int FL_SLI  = 5;
  localparam int FL_SUSP = 1;

  localparam logic [1:0] RSP_OK    = 2'd0;
  localparam logic [1:0] RSP_UNSUP = 2'd1;
  localparam logic [1:0] RSP_BUSY  = 2'd2;
  localparam logic [1:0] RSP_FAULT = 2'd3;

  typedef enum logic [2:0] {
    OUT_OK   = 3'd0,
    OUT_UNIT = 3'd1,
    OUT_DATA = 3'd2,
    OUT_PROG = 3'd3,
    OUT_BUSY = 3'd4,
    OUT_SUSP = 3'd5
  } outcome_e;

  typedef enum logic [2:0] {
    ACT_PCHK, ACT_SUSP, ACT_NOOP, ACT_BSENSE, ACT_SID, ACT_JUMP, ACT_DEV
  } action_e;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC, ST_DEV} state_e;

  typedef struct packed {
    logic [7:0]  cmd;
    logic [7:0]  flags;
    logic [15:0] count;
    logic [31:0] addr;
  } ccw_t;

  // Bytes actually moved: the smaller of request and natural size
  function automatic logic [15:0] xfer_len(input logic [15:0] cnt, input logic [15:0] nat);
    return (cnt < nat) ? cnt : nat;
  endfunction

  // Leading identification byte: marker only when four bytes fit
  function automatic logic [7:0] sid_lead(input logic [15:0] len);
    return (len >= 16'd4) ? 8'hFF : 8'h00;
  endfunction

  // Count must match unless suppress-length applies without data chaining
  function automatic logic len_checked(input logic [7:0] fl);
    return !(fl[FL_SLI] && !fl[FL_DC]);
  endfunction

  function automatic logic outcome_alert(input outcome_e o);
    return (o != OUT_OK) && (o != OUT_SUSP);
  endfunction

endpackage

// File: rtl/ccw_word_check.sv
module ccw_word_check
  import ccw_pkg::*;
#(
  parameter int SENSE_BYTES = 32,
  parameter int SID_BYTES   = 8
) (
  input  logic [7:0]  cmd_i,
  input  logic [7:0]  flags_i,
  input  logic [15:0] count_i,
  input  logic        prev_jump_i,
  output action_e     action_o
);

  localparam logic [15:0] SENSE_N = 16'(SENSE_BYTES);
  localparam logic [15:0] SID_N   = 16'(SID_BYTES);

  logic chk_len;
  logic unused_flags;
  assign chk_len      = len_checked(flags_i);
  assign unused_flags = ^{flags_i[4:2], flags_i[0]};

  always_comb begin
    action_o = ACT_DEV;
    if (cmd_i[3:0] == 4'h0) begin
      action_o = ACT_PCHK;
    end else if (cmd_i[3:0] == OP_JUMP[3:0] && cmd_i[7:4] != 4'h0) begin
      action_o = ACT_PCHK;
    end else if (flags_i[FL_SUSP]) begin
      action_o = ACT_SUSP;
    end else begin
      case (cmd_i)
        OP_NOOP:   action_o = ACT_NOOP;
        OP_BSENSE: action_o = (chk_len && count_i != SENSE_N) ? ACT_PCHK : ACT_BSENSE;
        OP_SID:    action_o = (chk_len && count_i != SID_N) ? ACT_PCHK : ACT_SID;
        OP_JUMP:   action_o = (prev_jump_i || flags_i[FL_CC] || flags_i[FL_DC])
                              ? ACT_PCHK : ACT_JUMP;
        default:   action_o = ACT_DEV;
      endcase
    end
  end

endmodule

// File: rtl/ccw_sense_store.sv
module ccw_sense_store (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       reject_i,
  output logic [7:0] lead_o
);

  logic [7:0] lead_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_q <= 8'h00;
    end else if (reject_i) begin
      lead_q <= 8'h80;
    end else if (clear_i) begin
      lead_q <= 8'h00;
    end
  end

  assign lead_o = lead_q;

endmodule

// File: rtl/ccw_chain_engine.sv
module ccw_chain_engine
  import ccw_pkg::*;
#(
  parameter int MAX_STEPS   = 256,
  parameter int SENSE_BYTES = 32,
  parameter int SID_BYTES   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [31:0] start_addr_i,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_gnt_i,
  input  logic        mem_fault_i,
  input  logic [63:0] mem_rdata_i,
  output logic        dev_req_o,
  output logic [7:0]  dev_cmd_o,
  output logic [7:0]  dev_flags_o,
  output logic [15:0] dev_count_o,
  output logic [31:0] dev_addr_o,
  input  logic        dev_ack_i,
  input  logic [1:0]  dev_resp_i,
  output logic        done_o,
  output logic [2:0]  outcome_o,
  output logic [1:0]  dcc_o,
  output logic        alert_o,
  output logic [15:0] residual_o,
  output logic [7:0]  byte0_o,
  output logic [31:0] pc_o
);

  localparam int STEP_W = $clog2(MAX_STEPS + 1);
  localparam logic [STEP_W-1:0] STEP_CAP = STEP_W'(MAX_STEPS);
  localparam logic [15:0] SENSE_N = 16'(SENSE_BYTES);
  localparam logic [15:0] SID_N   = 16'(SID_BYTES);

  state_e            state_q;
  logic [31:0]       pc_q;
  logic [STEP_W-1:0] steps_q;
  logic              prev_jump_q;
  ccw_t              word_q;
  logic              done_q;
  outcome_e          outcome_q;
  logic [1:0]        dcc_q;
  logic              alert_q;
  logic [15:0]       residual_q;
  logic [7:0]        byte0_q;

  action_e    action;
  logic [7:0] sense_lead;
  logic [15:0] bs_len, sid_len;

  // Named internal events
  logic     fetch_blocked, latch_word, word_ok, chain_next, jump_take, go_dev;
  logic     fin;
  outcome_e fin_code;
  logic     sense_clear, sense_reject;

  ccw_word_check #(.SENSE_BYTES(SENSE_BYTES), .SID_BYTES(SID_BYTES)) u_check (
    .cmd_i       (word_q.cmd),
    .flags_i     (word_q.flags),
    .count_i     (word_q.count),
    .prev_jump_i (prev_jump_q),
    .action_o    (action)
  );

  ccw_sense_store u_sense (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (sense_clear),
    .reject_i (sense_reject),
    .lead_o   (sense_lead)
  );

  assign bs_len  = xfer_len(word_q.count, SENSE_N);
  assign sid_len = xfer_len(word_q.count, SID_N);

  assign fetch_blocked = (pc_q == 32'h0) || (steps_q == STEP_CAP);
  assign sense_clear   = (state_q == ST_EXEC) && (action == ACT_BSENSE);
  assign sense_reject  = (state_q == ST_DEV) && dev_ack_i && (dev_resp_i == RSP_UNSUP);

  always_comb begin
    fin        = 1'b0;
    fin_code   = OUT_OK;
    latch_word = 1'b0;
    word_ok    = 1'b0;
    jump_take  = 1'b0;
    go_dev     = 1'b0;
    case (state_q)
      ST_FETCH: begin
        if (fetch_blocked) begin
          fin = 1'b1; fin_code = OUT_PROG;
        end else if (mem_gnt_i) begin
          if (mem_fault_i) begin
            fin = 1'b1; fin_code = OUT_DATA;
          end else begin
            latch_word = 1'b1;
          end
        end
      end
      ST_EXEC: begin
        case (action)
          ACT_PCHK: begin fin = 1'b1; fin_code = OUT_PROG; end
          ACT_SUSP: begin fin = 1'b1; fin_code = OUT_SUSP; end
          ACT_JUMP: jump_take = 1'b1;
          ACT_DEV:  go_dev = 1'b1;
          default:  word_ok = 1'b1;
        endcase
      end
      ST_DEV: begin
        if (dev_ack_i) begin
          case (dev_resp_i)
            RSP_OK:    word_ok = 1'b1;
            RSP_UNSUP: begin fin = 1'b1; fin_code = OUT_UNIT; end
            RSP_BUSY:  begin fin = 1'b1; fin_code = OUT_BUSY; end
            default:   begin fin = 1'b1; fin_code = OUT_DATA; end
          endcase
        end
      end
      default: ;
    endcase
    if (word_ok && !word_q.flags[FL_CC]) begin
      fin = 1'b1; fin_code = OUT_OK;
    end
  end

  assign chain_next = word_ok && word_q.flags[FL_CC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pc_q        <= 32'h0;
      steps_q     <= '0;
      prev_jump_q <= 1'b0;
      word_q      <= '0;
      done_q      <= 1'b0;
      outcome_q   <= OUT_OK;
      dcc_q       <= 2'd0;
      alert_q     <= 1'b0;
      residual_q  <= 16'h0;
      byte0_q     <= 8'h0;
    end else begin
      done_q <= fin;
      if (state_q == ST_IDLE && start_i) begin
        pc_q        <= start_addr_i;
        steps_q     <= '0;
        prev_jump_q <= 1'b0;
        state_q     <= ST_FETCH;
      end
      if (latch_word) begin
        word_q  <= ccw_t'(mem_rdata_i);
        steps_q <= steps_q + 1'b1;
        state_q <= ST_EXEC;
      end
      if (state_q == ST_EXEC) begin
        prev_jump_q <= (action == ACT_JUMP);
        case (action)
          ACT_BSENSE: begin
            residual_q <= word_q.count - bs_len;
            byte0_q    <= (bs_len != 16'h0) ? sense_lead : 8'h00;
          end
          ACT_SID: begin
            residual_q <= word_q.count - sid_len;
            byte0_q    <= sid_lead(sid_len);
          end
          default: begin
            residual_q <= word_q.count;
            byte0_q    <= 8'h00;
          end
        endcase
      end
      if (go_dev) state_q <= ST_DEV;
      if (jump_take) begin
        pc_q    <= word_q.addr;
        state_q <= ST_FETCH;
      end
      if (chain_next) begin
        pc_q    <= pc_q + 32'd8;
        state_q <= ST_FETCH;
      end
      if (fin) begin
        state_q   <= ST_IDLE;
        outcome_q <= fin_code;
        alert_q   <= outcome_alert(fin_code);
        dcc_q     <= (fin_code == OUT_BUSY) ? 2'd1 : 2'd0;
      end
    end
  end

  assign mem_req_o   = (state_q == ST_FETCH) && !fetch_blocked;
  assign mem_addr_o  = pc_q;
  assign dev_req_o   = (state_q == ST_DEV);
  assign dev_cmd_o   = word_q.cmd;
  assign dev_flags_o = word_q.flags;
  assign dev_count_o = word_q.count;
  assign dev_addr_o  = word_q.addr;
  assign done_o      = done_q;
  assign outcome_o   = outcome_q;
  assign dcc_o       = dcc_q;
  assign alert_o     = alert_q;
  assign residual_o  = residual_q;
  assign byte0_o     = byte0_q;
  assign pc_o        = pc_q;

endmodule

// File: rtl/ccw_chain_engine_chk.sv
module ccw_chain_engine_chk #(
  parameter int MAX_STEPS = 256
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req_o,
  input logic        mem_gnt_i,
  input logic [31:0] mem_addr_o,
  input logic        dev_req_o,
  input logic        dev_ack_i,
  input logic        done_o,
  input logic [2:0]  outcome_o,
  input logic [1:0]  dcc_o,
  input logic        alert_o,
  input logic        chain_next
);

  localparam int CNT_W = $clog2(MAX_STEPS + 1) + 1;
  logic [CNT_W-1:0] grants;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      grants <= '0;
    else if (done_o)                 grants <= '0;
    else if (mem_req_o && mem_gnt_i) grants <= grants + 1'b1;
  end

  // R12
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_o && dev_req_o));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  busy_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && outcome_o == 3'd4) |-> (dcc_o == 2'd1 && alert_o));

  // R5
  ok_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && outcome_o == 3'd0) |-> (!alert_o && dcc_o == 2'd0));

  // R3
  susp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && outcome_o == 3'd5) |-> (!alert_o && dcc_o == 2'd0));

  // R1
  zero_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_addr_o != 32'h0));

  // R10
  step_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (grants < CNT_W'(MAX_STEPS)));

  // R5
  chain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_next |=> (mem_addr_o == $past(mem_addr_o) + 32'd8));

  // R8
  dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req_o && !dev_ack_i) |=> dev_req_o);

endmodule

bind ccw_chain_engine ccw_chain_engine_chk #(.MAX_STEPS(MAX_STEPS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req_o  (mem_req_o),
  .mem_gnt_i  (mem_gnt_i),
  .mem_addr_o (mem_addr_o),
  .dev_req_o  (dev_req_o),
  .dev_ack_i  (dev_ack_i),
  .done_o     (done_o),
  .outcome_o  (outcome_o),
  .dcc_o      (dcc_o),
  .alert_o    (alert_o),
  .chain_next (chain_next)
);

// File: tb/ccw_chain_engine_tb.sv
`timescale 1ns/100ps
module ccw_chain_engine_tb;

  localparam int OK = 0, UNIT = 1, DATA = 2, PROG = 3, BUSY = 4, SUSP = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] start_addr_i = 32'h0;
  logic        mem_req_o, mem_gnt_i = 1'b0, mem_fault_i = 1'b0;
  logic [31:0] mem_addr_o;
  logic [63:0] mem_rdata_i = 64'h0;
  logic        dev_req_o, dev_ack_i = 1'b0;
  logic [1:0]  dev_resp_i = 2'd0;
  logic [7:0]  dev_cmd_o, dev_flags_o;
  logic [15:0] dev_count_o;
  logic [31:0] dev_addr_o;
  logic        done_o, alert_o;
  logic [2:0]  outcome_o;
  logic [1:0]  dcc_o;
  logic [15:0] residual_o;
  logic [7:0]  byte0_o;
  logic [31:0] pc_o;

  int n_chk = 0;
  int n_err = 0;
  int grants = 0;
  logic [1:0]  rsp_sel = 2'd0;
  logic [63:0] mem [64];

  always #2.5 clk = ~clk;

  ccw_chain_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i),
    .mem_fault_i(mem_fault_i), .mem_rdata_i(mem_rdata_i),
    .dev_req_o(dev_req_o), .dev_cmd_o(dev_cmd_o), .dev_flags_o(dev_flags_o),
    .dev_count_o(dev_count_o), .dev_addr_o(dev_addr_o), .dev_ack_i(dev_ack_i),
    .dev_resp_i(dev_resp_i), .done_o(done_o), .outcome_o(outcome_o),
    .dcc_o(dcc_o), .alert_o(alert_o), .residual_o(residual_o),
    .byte0_o(byte0_o), .pc_o(pc_o)
  );

  // Memory and device responders, driven away from the active edge
  always @(negedge clk) begin
    mem_gnt_i   = mem_req_o;
    mem_fault_i = mem_addr_o[31];
    mem_rdata_i = mem[mem_addr_o[8:3]];
    if (mem_req_o) grants++;
    dev_ack_i  = dev_req_o;
    dev_resp_i = rsp_sel;
  end

  function automatic logic [63:0] mk(input logic [7:0] c, input logic [7:0] f,
                                     input logic [15:0] n, input logic [31:0] a);
    return {c, f, n, a};
  endfunction

  typedef struct packed {
    logic [31:0] start;
    logic [63:0] w0, w1, w2;
    logic [1:0]  rsp;
    logic [2:0]  out;
    logic        chk_data;
    logic [15:0] res;
    logic [7:0]  b0;
    logic [31:0] pc;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    // R5 single no-op
    '{32'h100, mk(8'h03,8'h00,16'd5,0), 64'h0, 64'h0, 2'd0, 3'd0, 1'b1, 16'd5, 8'h00, 32'h100, 4'd5},
    // R5 chained no-ops advance by 8
    '{32'h100, mk(8'h03,8'h40,16'd1,0), mk(8'h03,8'h40,16'd2,0), mk(8'h03,8'h00,16'd7,0), 2'd0, 3'd0, 1'b1, 16'd7, 8'h00, 32'h110, 4'd5},
    // R1 low nibble zero
    '{32'h100, mk(8'h10,8'h00,16'd1,0), 64'h0, 64'h0, 2'd0, 3'd3, 1'b1, 16'd1, 8'h00, 32'h100, 4'd1},
    // R2 jump with non-zero high nibble
    '{32'h100, mk(8'h18,8'h00,16'd1,32'h110), 64'h0, 64'h0, 2'd0, 3'd3, 1'b1, 16'd1, 8'h00, 32'h100, 4'd2},
    // R2 valid jump skips the bad word
    '{32'h100, mk(8'h08,8'h00,16'd0,32'h110), mk(8'h00,8'h00,16'd0,0), mk(8'h03,8'h00,16'd9,0), 2'd0, 3'd0, 1'b1, 16'd9, 8'h00, 32'h110, 4'd2},
    // R2 jump right after jump
    '{32'h100, mk(8'h08,8'h00,16'd0,32'h108), mk(8'h08,8'h00,16'd0,32'h110), mk(8'h03,8'h00,16'd1,0), 2'd0, 3'd3, 1'b1, 16'd0, 8'h00, 32'h108, 4'd2},
    // R2 jump with command chain
    '{32'h100, mk(8'h08,8'h40,16'd0,32'h110), 64'h0, mk(8'h03,8'h00,16'd1,0), 2'd0, 3'd3, 1'b1, 16'd0, 8'h00, 32'h100, 4'd2},
    // R4 basic sense short count, checked
    '{32'h100, mk(8'h04,8'h00,16'd3,0), 64'h0, 64'h0, 2'd0, 3'd3, 1'b1, 16'd3, 8'h00, 32'h100, 4'd4},
    // R4 suppress length with data chain still checked
    '{32'h100, mk(8'h04,8'hA0,16'd3,0), 64'h0, 64'h0, 2'd0, 3'd3, 1'b1, 16'd3, 8'h00, 32'h100, 4'd4},
    // R8 unsupported device command
    '{32'h100, mk(8'h01,8'h00,16'd4,0), 64'h0, 64'h0, 2'd1, 3'd1, 1'b1, 16'd4, 8'h00, 32'h100, 4'd8},
    // R3 suspended basic sense is not executed
    '{32'h100, mk(8'h04,8'h02,16'd32,0), 64'h0, 64'h0, 2'd0, 3'd5, 1'b1, 16'd32, 8'h00, 32'h100, 4'd3},
    // R7 basic sense returns 0x80 left by the reject
    '{32'h100, mk(8'h04,8'h00,16'd32,0), 64'h0, 64'h0, 2'd0, 3'd0, 1'b1, 16'd0, 8'h80, 32'h100, 4'd7},
    // R7 second basic sense finds it zeroed
    '{32'h100, mk(8'h04,8'h00,16'd32,0), 64'h0, 64'h0, 2'd0, 3'd0, 1'b1, 16'd0, 8'h00, 32'h100, 4'd7},
    // R6 sense-ID two bytes
    '{32'h100, mk(8'hE4,8'h20,16'd2,0), 64'h0, 64'h0, 2'd0, 3'd0, 1'b1, 16'd0, 8'h00, 32'h100, 4'd6},
    // R6 sense-ID oversized request
    '{32'h100, mk(8'hE4,8'h20,16'd20,0), 64'h0, 64'h0, 2'd0, 3'd0, 1'b1, 16'd12, 8'hFF, 32'h100, 4'd6},
    // R6 sense-ID exact size
    '{32'h100, mk(8'hE4,8'h00,16'd8,0), 64'h0, 64'h0, 2'd0, 3'd0, 1'b1, 16'd0, 8'hFF, 32'h100, 4'd6},
    // R4 sense-ID wrong size, checked
    '{32'h100, mk(8'hE4,8'h00,16'd6,0), 64'h0, 64'h0, 2'd0, 3'd3, 1'b1, 16'd6, 8'h00, 32'h100, 4'd4},
    // R9 busy device
    '{32'h100, mk(8'h02,8'h00,16'd3,0), 64'h0, 64'h0, 2'd2, 3'd4, 1'b1, 16'd3, 8'h00, 32'h100, 4'd9},
    // R8 device fault
    '{32'h100, mk(8'h02,8'h00,16'd3,0), 64'h0, 64'h0, 2'd3, 3'd2, 1'b1, 16'd3, 8'h00, 32'h100, 4'd8},
    // R8 accepted device command chains on
    '{32'h100, mk(8'h01,8'h40,16'd1,0), mk(8'h03,8'h00,16'd2,0), 64'h0, 2'd0, 3'd0, 1'b1, 16'd2, 8'h00, 32'h108, 4'd8},
    // R8 memory fault on fetch
    '{32'h8000_0000, 64'h0, 64'h0, 64'h0, 2'd0, 3'd2, 1'b0, 16'd0, 8'h00, 32'h8000_0000, 4'd8},
    // R1 zero start address
    '{32'h0, 64'h0, 64'h0, 64'h0, 2'd0, 3'd3, 1'b0, 16'd0, 8'h00, 32'h0, 4'd1},
    // R1 jump to address zero
    '{32'h100, mk(8'h08,8'h00,16'd0,32'h0), 64'h0, 64'h0, 2'd0, 3'd3, 1'b0, 16'd0, 8'h00, 32'h0, 4'd1},
    // R4 suppress length accepts a zero count
    '{32'h100, mk(8'h04,8'h20,16'd0,0), 64'h0, 64'h0, 2'd0, 3'd0, 1'b1, 16'd0, 8'h00, 32'h100, 4'd4}
  };

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] sa, output bit ok);
    ok = 1'b0;
    @(negedge clk);
    start_addr_i = sa;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (done_o) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    bit ok;
    for (int i = 0; i < 64; i++) mem[i] = 64'h0;
    // R11 reset state
    repeat (3) @(negedge clk);
    check(11, "done in reset", 32'(done_o), 0);
    check(11, "mem_req in reset", 32'(mem_req_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(11, "done after reset", 32'(done_o), 0);
    check(11, "mem_req idle", 32'(mem_req_o), 0);
    check(11, "dev_req idle", 32'(dev_req_o), 0);

    for (int v = 0; v < NV; v++) begin
      mem[32] = VECS[v].w0;
      mem[33] = VECS[v].w1;
      mem[34] = VECS[v].w2;
      rsp_sel = VECS[v].rsp;
      run(VECS[v].start, ok);
      check(int'(VECS[v].req), "completed", 32'(ok), 1);
      check(int'(VECS[v].req), "outcome", 32'(outcome_o), 32'(VECS[v].out));
      check(int'(VECS[v].req), "end address", pc_o, VECS[v].pc);
      check(int'(VECS[v].req), "deferred code", 32'(dcc_o),
            (VECS[v].out == 3'(BUSY)) ? 32'd1 : 32'd0);
      check(int'(VECS[v].req), "alert", 32'(alert_o),
            (VECS[v].out == 3'(OK) || VECS[v].out == 3'(SUSP)) ? 32'd0 : 32'd1);
      if (VECS[v].chk_data) begin
        check(int'(VECS[v].req), "residual", 32'(residual_o), 32'(VECS[v].res));
        check(int'(VECS[v].req), "sense byte", 32'(byte0_o), 32'(VECS[v].b0));
      end
      // R12 one-cycle completion pulse
      @(negedge clk);
      check(12, "done width", 32'(done_o), 0);
    end

    // R10 runaway loop: no-op with chaining, then jump back
    mem[32] = mk(8'h03, 8'h40, 16'd1, 32'h0);
    mem[33] = mk(8'h08, 8'h00, 16'd0, 32'h100);
    rsp_sel = 2'd0;
    grants = 0;
    run(32'h100, ok);
    check(10, "loop completed", 32'(ok), 1);
    check(10, "loop outcome", 32'(outcome_o), PROG);
    check(10, "words fetched", grants, 256);
    check(10, "loop end address", pc_o, 32'h100);

    // R12 start ignored while busy is not observable here; confirm idle again
    repeat (2) @(negedge clk);
    check(12, "idle requests", 32'(mem_req_o | dev_req_o), 0);

    summary();
    $finish;
  end

endmodule